// File: doc/BRIEF.md
# Stretchable External Data Bus Controller

This block serves the data-memory read and write requests of a processor core. Each accepted request goes to one of two places. It can go to an on-chip 1 KB data SRAM, or it can go out onto an external bus that multiplexes the low address byte with the data. A two-bit map selector chooses which 1 KB window of the address space, if any, is decoded to the on-chip array. Every address outside that window goes to the external bus. The on-chip array is reached only through this data path and is never used for instruction fetch.

An external access is built from four phases: an address phase with the latch enable high, a setup gap, a strobe, and a hold gap. A three-bit stretch value, sampled when the request is accepted, widens the strobe by whole machine cycles. Any nonzero stretch also lengthens the setup gap and the hold gap by one clock each. An on-chip access always takes the minimum two machine cycles and drives no external strobe. Every access ends with a done pulse that lasts one clock. Read data is returned together with that pulse.

Top module: `xdata_bus_ctrl`

## Requirements
- R1: While reset is held low: done is 0, both strobes (active low) are 1, the address latch enable is 0, the bus output enable is 0, and the SRAM enable is 0.
- R2: Map selector decode, with the 16-bit address: 00 maps nothing on chip; 01 maps 0x0000–0x03FF; 10 maps 0x0400–0x07FF; 11 maps 0xFC00–0xFFFF. An access that hits the window goes on chip with array index addr[9:0]. Every other access goes to the external bus.
- R3: A request is accepted at a rising edge while the block is idle. An external access with stretch 0 asserts done in the 8th clock after acceptance. Its phases are address 2 clocks, setup 1, strobe 4, hold 1.
- R4: An external access with stretch s from 1 to 7 has a strobe of 4·(s+1) clocks and setup and hold gaps of 2 clocks each. Done comes in clock 10+4·s.
- R5: The address latch enable is high for exactly the first 2 clocks of an external access, with the output enable high and addr[7:0] on the bus output. It never overlaps a strobe.
- R6: An external read pulls only the read strobe low and keeps the bus output enable low from the setup gap onward. It samples the bus input in the last strobe clock and presents that value on rdata while done is high.
- R7: An external write pulls only the write strobe low and drives the write data with the output enable high through setup, strobe and hold.
- R8: An on-chip access asserts done in the 8th clock whatever the stretch value, with no latch enable and no strobe. It raises the SRAM enable for its first clock only, with the SRAM write enable equal to the direction. A read returns the array output, which arrives one clock after the enable, on rdata with done.
- R9: Done is high for exactly one clock per access.
- R10: Requests and changes to address, stretch or direction while an access is in progress are ignored. The access completes with the values sampled at acceptance, and no new access starts afterwards unless a request is present.
- R11: For the whole of an external access, the high address output equals addr[15:8] of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request from the core |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Data address |
| wdata | input | 8 | Write data |
| map_sel | input | 2 | On-chip window selector |
| stretch | input | 3 | Strobe stretch, 0..7 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data |
| ext_addr_hi | output | 8 | External high address byte |
| ext_ad_out | output | 8 | Multiplexed address/data bus output |
| ext_ad_oe | output | 1 | Bus output enable |
| ext_ad_in | input | 8 | Multiplexed bus input |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| sram_en | output | 1 | On-chip array enable |
| sram_we | output | 1 | On-chip array write enable |
| sram_addr | output | 10 | On-chip array index |
| sram_wdata | output | 8 | On-chip array write data |
| sram_rdata | input | 8 | On-chip array read data, one clock latency |

## Verification
Every result is timed from the accepting edge. The bench raises the request before that edge, then samples all outputs at each falling edge and numbers those samples 1, 2, 3 and so on. The latch enable is due in samples 1–2. The strobe starts at sample 4 with stretch 0 and at sample 5 otherwise. Done is due at sample 8 for on-chip accesses and at sample 8, or 10+4·s, for external ones. The phase widths come from the sample numbers at which each signal first and last appears. The bench compares them with values it derives from the stretch, and rdata is read in the same sample as done. One further sample after done confirms that the pulse has fallen and that no access has restarted.

// File: rtl/xdb_pkg.sv
package xdb_pkg;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ADDR,
    XS_SETUP,
    XS_STROBE,
    XS_HOLD,
    XS_INT
  } xdb_state_e;

  // clocks in each of the setup and hold gaps
  function automatic int unsigned xdb_gap_clks(input logic [2:0] s);
    return (s == 3'd0) ? 1 : 2;
  endfunction

  // strobe width in clocks for a given stretch and clocks per machine cycle
  function automatic int unsigned xdb_strobe_clks(input logic [2:0] s, input int unsigned mc);
    return mc * (int'(s) + 1);
  endfunction

endpackage

// File: rtl/xdb_map.sv
module xdb_map #(
  parameter int ADDR_W  = 16,
  parameter int SRAM_AW = 10
) (
  input  logic [1:0]        map_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int HI_W = ADDR_W - SRAM_AW;

  logic [HI_W-1:0] win_idx;
  assign win_idx = addr[ADDR_W-1:SRAM_AW];

  always_comb begin
    unique case (map_sel)
      2'b01:   hit = (win_idx == HI_W'(0));
      2'b10:   hit = (win_idx == HI_W'(1));
      2'b11:   hit = (win_idx == {HI_W{1'b1}});
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/xdb_seq.sv
module xdb_seq
  import xdb_pkg::*;
#(
  parameter int MC    = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_int,
  input  logic [2:0]       stretch_q,
  output xdb_state_e       state,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_last
);
  localparam int ADDR_CLKS = MC - 2;
  localparam int INT_CLKS  = 2 * MC;

  logic [CNT_W-1:0] len;

  always_comb begin
    unique case (state)
      XS_ADDR:           len = CNT_W'(ADDR_CLKS);
      XS_SETUP, XS_HOLD: len = CNT_W'(xdb_gap_clks(stretch_q));
      XS_STROBE:         len = CNT_W'(xdb_strobe_clks(stretch_q, MC));
      XS_INT:            len = CNT_W'(INT_CLKS);
      default:           len = CNT_W'(1);
    endcase
  end

  assign phase_last = (cnt == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= XS_IDLE;
      cnt   <= '0;
    end else if (state == XS_IDLE) begin
      cnt <= '0;
      if (start) state <= start_int ? XS_INT : XS_ADDR;
    end else if (phase_last) begin
      cnt <= '0;
      unique case (state)
        XS_ADDR:   state <= XS_SETUP;
        XS_SETUP:  state <= XS_STROBE;
        XS_STROBE: state <= XS_HOLD;
        default:   state <= XS_IDLE;
      endcase
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assert_addr_to_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XS_ADDR && phase_last) |=> state == XS_SETUP);

  assert_strobe_to_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XS_STROBE && phase_last) |=> state == XS_HOLD);
endmodule

// File: rtl/xdb_drive.sv
module xdb_drive
  import xdb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SRAM_AW = 10,
  parameter int CNT_W   = 6
) (
  input  xdb_state_e        state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              lat_we,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
  output logic [DATA_W-1:0] ext_ad_out,
  output logic              ext_ad_oe,
  output logic              ext_ale,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic              sram_en,
  output logic              sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata
);
  logic addr_ph, data_ph, strobe_ph;

  assign addr_ph   = (state == XS_ADDR);
  assign strobe_ph = (state == XS_STROBE);
  assign data_ph   = (state == XS_SETUP) || strobe_ph || (state == XS_HOLD);

  assign ext_ale     = addr_ph;
  assign ext_rd_n    = !(strobe_ph && !lat_we);
  assign ext_wr_n    = !(strobe_ph && lat_we);
  assign ext_ad_oe   = addr_ph || (data_ph && lat_we);
  assign ext_ad_out  = addr_ph ? lat_addr[DATA_W-1:0] : lat_wdata;
  assign ext_addr_hi = lat_addr[ADDR_W-1:DATA_W];

  assign sram_en    = (state == XS_INT) && (cnt == '0);
  assign sram_we    = sram_en && lat_we;
  assign sram_addr  = lat_addr[SRAM_AW-1:0];
  assign sram_wdata = lat_wdata;
endmodule

// File: rtl/xdata_bus_ctrl.sv
module xdata_bus_ctrl
  import xdb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SRAM_AW = 10,
  parameter int MC      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [1:0]               map_sel,
  input  logic [2:0]               stretch,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
  output logic [DATA_W-1:0]        ext_ad_out,
  output logic                     ext_ad_oe,
  input  logic [DATA_W-1:0]        ext_ad_in,
  output logic                     ext_ale,
  output logic                     ext_rd_n,
  output logic                     ext_wr_n,
  output logic                     sram_en,
  output logic                     sram_we,
  output logic [SRAM_AW-1:0]       sram_addr,
  output logic [DATA_W-1:0]        sram_wdata,
  input  logic [DATA_W-1:0]        sram_rdata
);
  localparam int CNT_W = $clog2(8 * MC + 1);

  xdb_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              phase_last;
  logic              hit, accept;
  logic              lat_we;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [2:0]        lat_stretch;
  logic              ext_busy, strobe_on;
  logic              cap_ext, cap_int;

  assign accept = req && (state == XS_IDLE);

  xdb_map #(.ADDR_W(ADDR_W), .SRAM_AW(SRAM_AW)) u_map (
    .map_sel(map_sel), .addr(addr), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_we      <= 1'b0;
      lat_addr    <= '0;
      lat_wdata   <= '0;
      lat_stretch <= '0;
    end else if (accept) begin
      lat_we      <= we;
      lat_addr    <= addr;
      lat_wdata   <= wdata;
      lat_stretch <= stretch;
    end
  end

  xdb_seq #(.MC(MC), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_int(hit),
    .stretch_q(lat_stretch), .state(state), .cnt(cnt), .phase_last(phase_last)
  );

  xdb_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRAM_AW(SRAM_AW), .CNT_W(CNT_W)) u_drive (
    .state(state), .cnt(cnt), .lat_we(lat_we), .lat_addr(lat_addr),
    .lat_wdata(lat_wdata), .ext_addr_hi(ext_addr_hi), .ext_ad_out(ext_ad_out),
    .ext_ad_oe(ext_ad_oe), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .sram_en(sram_en), .sram_we(sram_we),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata)
  );

  assign done      = ((state == XS_HOLD) || (state == XS_INT)) && phase_last;
  assign ext_busy  = (state != XS_IDLE) && (state != XS_INT);
  assign strobe_on = !ext_rd_n || !ext_wr_n;
  assign cap_ext   = (state == XS_STROBE) && phase_last && !lat_we;
  assign cap_int   = (state == XS_INT) && (cnt == CNT_W'(1)) && !lat_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (cap_ext) rdata <= ext_ad_in;
    else if (cap_int) rdata <= sram_rdata;
  end

  // run length of the current strobe, for the width check
  logic [CNT_W-1:0] strobe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         strobe_run <= '0;
    else if (strobe_on) strobe_run <= strobe_run + CNT_W'(1);
    else                strobe_run <= '0;
  end

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  assert_ale_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |-> (ext_rd_n && ext_wr_n));

  assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_onchip_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XS_INT) |-> (ext_rd_n && ext_wr_n && !ext_ale));

  assert_hi_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_busy && $past(ext_busy)) |-> $stable(ext_addr_hi));

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_on) |-> (strobe_run == CNT_W'(xdb_strobe_clks(lat_stretch, MC))));
endmodule

// File: tb/xdata_bus_ctrl_tb.sv
module xdata_bus_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, ext_ad_in = '0, sram_rdata = '0;
  logic [1:0]  map_sel = '0;
  logic [2:0]  stretch = '0;
  logic        done, ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n, sram_en, sram_we;
  logic [7:0]  rdata, ext_addr_hi, ext_ad_out, sram_wdata;
  logic [9:0]  sram_addr;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem    [1024];
  logic [7:0] shadow [1024];

  always #(CLK_P/2) clk = ~clk;

  xdata_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .map_sel(map_sel), .stretch(stretch), .done(done), .rdata(rdata),
    .ext_addr_hi(ext_addr_hi), .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe),
    .ext_ad_in(ext_ad_in), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .sram_en(sram_en), .sram_we(sram_we),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  // on-chip array model, one clock read latency
  always @(posedge clk) begin
    if (sram_en) begin
      if (sram_we) mem[sram_addr] <= sram_wdata;
      else         sram_rdata     <= mem[sram_addr];
    end
  end

  // {we, map_sel, stretch, addr, data}
  localparam logic [29:0] VECS [NV] = '{
    {1'b0, 2'b00, 3'd0, 16'h0123, 8'h3C},
    {1'b1, 2'b00, 3'd0, 16'h8456, 8'h96},
    {1'b0, 2'b01, 3'd1, 16'h0400, 8'h11},
    {1'b1, 2'b01, 3'd3, 16'h1234, 8'h7E},
    {1'b1, 2'b01, 3'd5, 16'h03FF, 8'hC3},
    {1'b0, 2'b01, 3'd7, 16'h03FF, 8'h00},
    {1'b1, 2'b10, 3'd0, 16'h0401, 8'h5A},
    {1'b0, 2'b10, 3'd2, 16'h0401, 8'h00},
    {1'b0, 2'b10, 3'd7, 16'h0001, 8'hE7},
    {1'b1, 2'b11, 3'd4, 16'hFC10, 8'h24},
    {1'b0, 2'b11, 3'd0, 16'hFC10, 8'h00},
    {1'b1, 2'b11, 3'd7, 16'hFBFF, 8'h81},
    {1'b0, 2'b01, 3'd0, 16'h0001, 8'h00}
  };

  function automatic bit tb_onchip(input logic [1:0] m, input logic [15:0] a);
    case (m)
      2'b01:   return a < 16'h0400;
      2'b10:   return a >= 16'h0400 && a < 16'h0800;
      2'b11:   return a >= 16'hFC00;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic run(input logic w, input logic [1:0] m, input logic [2:0] s,
                     input logic [15:0] a, input logic [7:0] d, input bit poke);
    bit on = tb_onchip(m, a);
    int gap = (s == 0) ? 1 : 2;
    int exp_t = on ? 8 : (2 + 2 * gap + 4 * (s + 1));
    int t_seen = 0, n_ale = 0, n_str = 0, first_s = 0, last_s = 0, last_ale = 0;
    int n_sen = 0, bad_ad = 0, bad_wd = 0, bad_oe = 0, bad_sel = 0, bad_hi = 0, bad_sram = 0;
    logic [7:0] rd_v = '0;
    logic [7:0] exp_rd = on ? shadow[a[9:0]] : d;
    @(negedge clk);
    we = w; map_sel = m; stretch = s; addr = a; wdata = d; ext_ad_in = d; req = 1'b1;
    for (int k = 1; k <= 60 && t_seen == 0; k++) begin
      @(negedge clk);
      if (k == 1) req = poke;
      if (poke && k <= 3) begin addr = 16'hABCD; stretch = 3'd7; we = !w; end
      if (k == 4) req = 1'b0;
      if (ext_ale) begin
        n_ale++; last_ale = k;
        if (ext_ad_out != a[7:0] || !ext_ad_oe) bad_ad++;
      end
      if (!ext_rd_n || !ext_wr_n) begin
        n_str++; if (first_s == 0) first_s = k; last_s = k;
        if (w ? !ext_rd_n : !ext_wr_n) bad_sel++;
        if (!w && ext_ad_oe) bad_oe++;
      end
      if (w && !on && k > 2 && (ext_ad_out != d || !ext_ad_oe)) bad_wd++;
      if (!w && !on && k > 2 && ext_ad_oe) bad_oe++;
      if (!on && ext_addr_hi != a[15:8]) bad_hi++;
      if (sram_en) begin
        n_sen++;
        if (sram_addr != a[9:0] || sram_we != w || k != 1) bad_sram++;
      end
      if (done) begin t_seen = k; rd_v = rdata; end
    end
    req = 1'b0;
    chk(t_seen == exp_t, on ? "R8 done clock" : (s == 0 ? "R3 done clock" : "R4 done clock"), t_seen, exp_t);
    if (on) begin
      chk(n_ale == 0 && n_str == 0, "R8 no external activity", n_ale + n_str, 0);
      chk(n_sen == 1 && bad_sram == 0, "R8 sram enable first clock", n_sen + bad_sram, 1);
      if (w) shadow[a[9:0]] = d;
    end else begin
      chk(n_ale == 2 && last_ale == 2 && bad_ad == 0, "R5 latch enable", n_ale * 10 + bad_ad, 20);
      chk(n_str == 4 * (s + 1), "R4 strobe width", n_str, 4 * (s + 1));
      chk(first_s - last_ale - 1 == gap, "R4 setup gap", first_s - last_ale - 1, gap);
      chk(t_seen - last_s == gap, "R4 hold gap", t_seen - last_s, gap);
      chk(bad_sel == 0 && bad_oe == 0 && bad_wd == 0, w ? "R7 write drive" : "R6 read strobe",
          bad_sel + bad_oe + bad_wd, 0);
      chk(bad_hi == 0, "R11 high address", bad_hi, 0);
      chk(n_sen == 0, "R2 routed external", n_sen, 0);
    end
    if (!w) chk(rd_v == exp_rd, on ? "R8 read data" : "R6 read data", rd_v, exp_rd);
    @(negedge clk);
    chk(!done, "R9 done one clock", done, 0);
    chk(!ext_ale && !sram_en, "R10 no restart", ext_ale + sram_en, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && ext_rd_n && ext_wr_n && !ext_ale && !ext_ad_oe && !sram_en,
        "R1 reset outputs", {done, ext_rd_n, ext_wr_n, ext_ale, ext_ad_oe, sram_en}, 6'b011000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && ext_rd_n && ext_wr_n && !ext_ale, "R1 idle after reset", done, 0);

    for (int v = 0; v < NV; v++)
      run(VECS[v][29], VECS[v][28:27], VECS[v][26:24], VECS[v][23:8], VECS[v][7:0], 1'b0);

    // R10: request held and inputs changed while busy
    run(1'b0, 2'b00, 3'd0, 16'h2233, 8'h6B, 1'b1);
    run(1'b1, 2'b01, 3'd2, 16'h0010, 8'h99, 1'b1);
    // R2: window edges
    run(1'b1, 2'b10, 3'd1, 16'h07FF, 8'h42, 1'b0);
    run(1'b0, 2'b10, 3'd1, 16'h0800, 8'h1F, 1'b0);
    run(1'b0, 2'b00, 3'd6, 16'h0000, 8'hD2, 1'b0);
    run(1'b0, 2'b11, 3'd0, 16'hFFFF, 8'h00, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule